// File: doc/BRIEF.md
# CPU Sleep-State and Clock-Throttle Sequencer

This block drives the processor clock-control pins of a chipset power-management unit. It tracks four processor power states: C0 (run), C1 (software halt), C2 (stop grant) and C3 (suspend). Register-read strobes from the power-management register decoder move it from C0 into C2 or C3, and a halt strobe moves it into C1. A wake event brings it back to C0. Three active-low outputs come from the state: the stop-clock request to the processor, the host clock-generator stop, and a suspend-status line. The suspend-status line tells the memory controller to refresh DRAM from the slow suspend clock.

Leaving C3 after the host clock has been stopped follows a fixed order. The host clock stop is released first. The block then waits a programmable number of cycles so the processor PLL can relock. Only after that does it release the suspend-status line and the stop-clock request. While in C0, the stop-clock output is pulsed over a repeating eight-slot window to throttle the processor. The duty cycle comes either from software or, when the thermal alarm pin is active, from a separate thermal setting.

Top module: `pm_cstate_seq`

## Requirements
- R1: After reset the state code `cstate_o` is 0, and all three active-low outputs are high when no throttle source is active. State codes are 0=C0, 1=C1, 2=C2, 3=C3.
- R2: `lvl2_rd_i` in C0 moves the block to C2 on the next clock. In C2, `stpclk_n_o` is low while `cpustp_n_o` and `susst_n_o` stay high.
- R3: `lvl3_rd_i` in C0 moves the block to C3 on the next clock, with `stpclk_n_o` and `susst_n_o` low. `cpustp_n_o` goes low only if `host_stop_en_i` was 1 in the cycle of the read. When strobes arrive together, the priority is `lvl3_rd_i`, then `lvl2_rd_i`, then `halt_i`.
- R4: `halt_i` in C0 moves the block to C1, where all three outputs are high. `wake_i` in C1 returns the block to C0 on the next clock.
- R5: `wake_i` in C2 returns the block to C0 on the next clock, releasing `stpclk_n_o`.
- R6: `wake_i` in C3 with the host stop active releases `cpustp_n_o` on the next clock. The state code stays 3, and `stpclk_n_o` and `susst_n_o` stay low for N+1 cycles, where N is `relock_cyc_i` sampled with the wake. Both then go high together as the block returns to C0.
- R7: `wake_i` in C3 without the host stop returns the block to C0 on the next clock, releasing all outputs at once.
- R8: Level-read and halt strobes outside C0 are ignored, and so is `wake_i` in C0. The state code and outputs do not change.
- R9: In C0 a slot counter steps 0..7 every clock and restarts at 0 on each entry to C0. `stpclk_n_o` is low in slots below the active 3-bit duty code, so code n gives n low cycles in every 8. Code 0 means no throttling.
- R10: `therm_n_i` is active low and passes through a two-flop synchronizer. While it is active, `therm_duty_i` is used whatever the software enable. Otherwise `sw_duty_i` is used when `sw_thr_en_i` is 1, and no throttling happens when it is 0.
- R11: Throttling applies only in C0. In C1, `stpclk_n_o` stays high for any duty setting. In C2 and C3 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl2_rd_i | input | 1 | Read strobe of the level-2 (stop grant) register |
| lvl3_rd_i | input | 1 | Read strobe of the level-3 (suspend) register |
| halt_i | input | 1 | Software halt strobe |
| wake_i | input | 1 | Wake/break event |
| host_stop_en_i | input | 1 | Allow host clock stop in C3 |
| therm_n_i | input | 1 | Thermal alarm pin, active low, asynchronous |
| sw_thr_en_i | input | 1 | Software throttle enable |
| sw_duty_i | input | DUTY_W | Software duty code |
| therm_duty_i | input | DUTY_W | Thermal duty code |
| relock_cyc_i | input | RELOCK_W | PLL relock wait in cycles |
| stpclk_n_o | output | 1 | Stop-clock request to processor, active low |
| cpustp_n_o | output | 1 | Host clock generator stop, active low |
| susst_n_o | output | 1 | Suspend status to memory controller, active low |
| cstate_o | output | 2 | Current processor state code |

## Verification
The assertions check, on every cycle, the relations between the outputs. A low host-clock stop always comes with the suspend-status and stop-clock lines low. The host-clock stop rises only while suspend status is still held. Each state code shows its own fixed output pattern, and C1 and C2 can only return to C0. The exact relock length, the strobe priority, the ignoring of strobes outside C0, the synchronizer latency and the throttle low-cycle counts per window depend on timing and stimulus history, so only the bench's directed and random scenarios can show them against its cycle model.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_HALT   = 3'd1,
    PS_GRANT  = 3'd2,
    PS_SUSP   = 3'd3,
    PS_RELOCK = 3'd4
  } pstate_e;

  // Externally visible state code: the relock phase still reports C3.
  function automatic logic [1:0] state_code(pstate_e s);
    case (s)
      PS_RUN:    return 2'd0;
      PS_HALT:   return 2'd1;
      PS_GRANT:  return 2'd2;
      default:   return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= RST_VAL;
        else        sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= {STAGES{RST_VAL}};
        else        sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pm_throttle.sv
module pm_throttle #(
  parameter int DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              alarm_i,
  input  logic              sw_en_i,
  input  logic [DUTY_W-1:0] sw_duty_i,
  input  logic [DUTY_W-1:0] th_duty_i,
  output logic              assert_o
);
  logic [DUTY_W-1:0] slot_q, slot_d;
  logic [DUTY_W-1:0] duty_sel;

  always_comb begin
    if (run_i) slot_d = slot_q + DUTY_W'(1);
    else       slot_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  // Thermal source wins over the software source.
  always_comb begin
    if (alarm_i)      duty_sel = th_duty_i;
    else if (sw_en_i) duty_sel = sw_duty_i;
    else              duty_sel = '0;
  end

  assign assert_o = run_i && (slot_q < duty_sel);
endmodule

// File: rtl/pm_relock_timer.sv
module pm_relock_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || (run_i && (cnt_q != '0));

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pm_cstate_seq.sv
module pm_cstate_seq
  import pm_seq_pkg::*;
#(
  parameter int DUTY_W      = 3,
  parameter int RELOCK_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lvl2_rd_i,
  input  logic                lvl3_rd_i,
  input  logic                halt_i,
  input  logic                wake_i,
  input  logic                host_stop_en_i,
  input  logic                therm_n_i,
  input  logic                sw_thr_en_i,
  input  logic [DUTY_W-1:0]   sw_duty_i,
  input  logic [DUTY_W-1:0]   therm_duty_i,
  input  logic [RELOCK_W-1:0] relock_cyc_i,
  output logic                stpclk_n_o,
  output logic                cpustp_n_o,
  output logic                susst_n_o,
  output logic [1:0]          cstate_o
);
  pstate_e state_q, state_d;
  logic    hstop_q, hstop_en;
  logic    therm_n_s;
  logic    thr_assert;
  logic    relock_zero, relock_load;
  logic    in_run, in_relock;

  pm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_therm_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (therm_n_i),
    .q_o   (therm_n_s)
  );

  assign in_run    = (state_q == PS_RUN);
  assign in_relock = (state_q == PS_RELOCK);

  pm_throttle #(.DUTY_W(DUTY_W)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (in_run),
    .alarm_i   (!therm_n_s),
    .sw_en_i   (sw_thr_en_i),
    .sw_duty_i (sw_duty_i),
    .th_duty_i (therm_duty_i),
    .assert_o  (thr_assert)
  );

  assign relock_load = (state_q == PS_SUSP) && wake_i && hstop_q;

  pm_relock_timer #(.CNT_W(RELOCK_W)) u_relock (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (relock_load),
    .load_val_i (relock_cyc_i),
    .run_i      (in_relock),
    .zero_o     (relock_zero)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_RUN: begin
        if (lvl3_rd_i)      state_d = PS_SUSP;
        else if (lvl2_rd_i) state_d = PS_GRANT;
        else if (halt_i)    state_d = PS_HALT;
      end
      PS_HALT, PS_GRANT: begin
        if (wake_i) state_d = PS_RUN;
      end
      PS_SUSP: begin
        if (wake_i) state_d = hstop_q ? PS_RELOCK : PS_RUN;
      end
      PS_RELOCK: begin
        if (relock_zero) state_d = PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  // Host-stop permission captured at the level-3 read
  assign hstop_en = in_run && lvl3_rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hstop_q <= 1'b0;
    else if (hstop_en) hstop_q <= host_stop_en_i;
  end

  // Output decode
  logic sleep_stp;
  assign sleep_stp  = (state_q == PS_GRANT) || (state_q == PS_SUSP) || in_relock;
  assign stpclk_n_o = !(sleep_stp || thr_assert);
  assign cpustp_n_o = !((state_q == PS_SUSP) && hstop_q);
  assign susst_n_o  = !((state_q == PS_SUSP) || in_relock);
  assign cstate_o   = state_code(state_q);
endmodule

// File: rtl/pm_cstate_seq_chk.sv
module pm_cstate_seq_chk #(
  parameter int DUTY_W      = 3,
  parameter int RELOCK_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lvl2_rd_i,
  input logic                lvl3_rd_i,
  input logic                halt_i,
  input logic                wake_i,
  input logic                host_stop_en_i,
  input logic                therm_n_i,
  input logic                sw_thr_en_i,
  input logic [DUTY_W-1:0]   sw_duty_i,
  input logic [DUTY_W-1:0]   therm_duty_i,
  input logic [RELOCK_W-1:0] relock_cyc_i,
  input logic                stpclk_n_o,
  input logic                cpustp_n_o,
  input logic                susst_n_o,
  input logic [1:0]          cstate_o
);
  AST_HOSTSTOP_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    !cpustp_n_o |-> (!susst_n_o && !stpclk_n_o && cstate_o == 2'd3)); // R3

  AST_SUSPEND_HOLDS_STP: assert property (@(posedge clk) disable iff (!rst_n)
    !susst_n_o |-> (!stpclk_n_o && cstate_o == 2'd3)); // R6

  AST_HOSTSTOP_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpustp_n_o) |-> !susst_n_o); // R6

  AST_GRANT_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate_o == 2'd2) |-> (!stpclk_n_o && cpustp_n_o && susst_n_o)); // R2

  AST_HALT_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate_o == 2'd1) |-> (stpclk_n_o && cpustp_n_o && susst_n_o)); // R11

  AST_RUN_NO_SLEEP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (cstate_o == 2'd0) |-> (cpustp_n_o && susst_n_o)); // R9

  AST_GRANT_LEAVES_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cstate_o) == 2'd2 && cstate_o != 2'd2) |-> (cstate_o == 2'd0)); // R5

  AST_HALT_LEAVES_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cstate_o) == 2'd1 && cstate_o != 2'd1) |-> (cstate_o == 2'd0)); // R4
endmodule

bind pm_cstate_seq pm_cstate_seq_chk #(
  .DUTY_W(DUTY_W), .RELOCK_W(RELOCK_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/pm_cstate_seq_tb_top.sv
`timescale 1ns/1ps
module pm_cstate_seq_tb_top;
  localparam int DW = 3;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lvl2_rd, lvl3_rd, halt, wake, hse, therm_n, sw_en;
  logic [DW-1:0] sw_duty, th_duty;
  logic [RW-1:0] relock;
  logic          stpclk_n, cpustp_n, susst_n;
  logic [1:0]    cstate;

  always #2.5 clk = ~clk;

  pm_cstate_seq #(.DUTY_W(DW), .RELOCK_W(RW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lvl2_rd_i(lvl2_rd), .lvl3_rd_i(lvl3_rd),
    .halt_i(halt), .wake_i(wake), .host_stop_en_i(hse), .therm_n_i(therm_n),
    .sw_thr_en_i(sw_en), .sw_duty_i(sw_duty), .therm_duty_i(th_duty),
    .relock_cyc_i(relock), .stpclk_n_o(stpclk_n), .cpustp_n_o(cpustp_n),
    .susst_n_o(susst_n), .cstate_o(cstate)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model: 0 run, 1 halt, 2 grant, 3 suspend, 4 relock
  int          m_st;
  logic [2:0]  m_slot;
  logic [RW-1:0] m_cnt;
  logic        m_hs, m_t1, m_t2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_slot <= '0; m_cnt <= '0; m_hs <= 1'b0; m_t1 <= 1'b1; m_t2 <= 1'b1;
    end else begin
      m_t1   <= therm_n;
      m_t2   <= m_t1;
      m_slot <= (m_st == 0) ? m_slot + 3'd1 : 3'd0;
      case (m_st)
        0: if (lvl3_rd) begin m_st <= 3; m_hs <= hse; end
           else if (lvl2_rd) m_st <= 2;
           else if (halt) m_st <= 1;
        1, 2: if (wake) m_st <= 0;
        3: if (wake) begin
             if (m_hs) begin m_st <= 4; m_cnt <= relock; end
             else m_st <= 0;
           end
        default: if (m_cnt == '0) m_st <= 0; else m_cnt <= m_cnt - 1'b1;
      endcase
    end
  end

  function automatic logic [2:0] exp_duty();
    if (!m_t2) return th_duty;
    if (sw_en) return sw_duty;
    return 3'd0;
  endfunction

  function automatic logic exp_stp();
    if (m_st >= 2) return 1'b0;
    if (m_st == 0) return !(m_slot < exp_duty());
    return 1'b1;
  endfunction

  function automatic logic exp_cpu();
    return !(m_st == 3 && m_hs);
  endfunction

  function automatic logic exp_sus();
    return !(m_st == 3 || m_st == 4);
  endfunction

  function automatic logic [1:0] exp_code();
    return (m_st >= 3) ? 2'd3 : 2'(m_st);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string tag);
    chk(tag, "cstate",   cstate,   exp_code());
    chk(tag, "stpclk_n", stpclk_n, exp_stp());
    chk(tag, "cpustp_n", cpustp_n, exp_cpu());
    chk(tag, "susst_n",  susst_n,  exp_sus());
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk_model(tag);
  endtask

  task automatic idle();
    lvl2_rd = 0; lvl3_rd = 0; halt = 0; wake = 0;
  endtask

  function automatic string tag_of_state();
    case (m_st)
      0: return "R9";
      1: return "R4";
      2: return "R2";
      3: return "R3";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst_n = 0; idle(); hse = 0; therm_n = 1; sw_en = 0;
    sw_duty = 0; th_duty = 0; relock = 0;
    repeat (3) @(negedge clk);
    chk_model("R1");
    chk("R1", "cstate reset", cstate, 0);
    rst_n = 1;
    tick("R1");
    chk("R1", "outs high", {stpclk_n, cpustp_n, susst_n}, 7);

    // C2 entry and exit
    lvl2_rd = 1; tick("R2"); idle();
    chk("R2", "cstate", cstate, 2);
    chk("R2", "pins", {stpclk_n, cpustp_n, susst_n}, 3);
    lvl3_rd = 1; halt = 1; tick("R8"); idle();
    chk("R8", "strobe ignored in C2", cstate, 2);
    wake = 1; tick("R5"); idle();
    chk("R5", "back to C0", cstate, 0);
    chk("R5", "stpclk released", stpclk_n, 1);
    wake = 1; tick("R8"); idle();
    chk("R8", "wake ignored in C0", cstate, 0);

    // C3 with host stop, relock 5
    hse = 1; relock = 8'd5;
    lvl3_rd = 1; lvl2_rd = 1; tick("R3"); idle();
    chk("R3", "priority to level-3", cstate, 3);
    chk("R3", "pins", {stpclk_n, cpustp_n, susst_n}, 0);
    hse = 0; tick("R3");
    chk("R3", "host stop held", cpustp_n, 0);
    wake = 1; tick("R6"); idle(); relock = 8'd40;
    chk("R6", "host stop released first", {stpclk_n, cpustp_n, susst_n}, 2);
    chk("R6", "code stays C3", cstate, 3);
    cnt = 0;
    while (susst_n == 1'b0 && cnt < 100) begin tick("R6"); cnt++; end
    chk("R6", "relock cycles after host release", cnt, 6);
    chk("R6", "stpclk with susst", stpclk_n, 1);

    // C3 without host stop
    hse = 0; lvl3_rd = 1; tick("R3"); idle();
    chk("R3", "no host stop", cpustp_n, 1);
    chk("R3", "suspend", susst_n, 0);
    wake = 1; tick("R7"); idle();
    chk("R7", "direct exit", {cstate, stpclk_n, cpustp_n, susst_n}, 7);

    // Relock of zero cycles
    hse = 1; relock = 0; lvl3_rd = 1; tick("R6"); idle();
    wake = 1; tick("R6"); idle();
    chk("R6", "zero relock one cycle", susst_n, 0);
    tick("R6");
    chk("R6", "zero relock done", {cstate, susst_n}, 1);

    // C1
    sw_en = 1; sw_duty = 3'd7;
    halt = 1; lvl2_rd = 0; tick("R4"); idle();
    chk("R4", "halt state", cstate, 1);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      lvl2_rd = (i == 2); lvl3_rd = (i == 4);
      tick("R11"); if (!stpclk_n) cnt++;
    end
    idle();
    chk("R11", "no throttle in C1", cnt, 0);
    chk("R8", "strobes ignored in C1", cstate, 1);
    wake = 1; tick("R4"); idle();
    chk("R4", "halt exit", cstate, 0);

    // Software throttle
    sw_duty = 3'd3; tick("R9");
    cnt = 0;
    for (int i = 0; i < 16; i++) begin tick("R9"); if (!stpclk_n) cnt++; end
    chk("R9", "sw duty 3 over 16", cnt, 6);
    sw_duty = 3'd0; cnt = 0;
    for (int i = 0; i < 8; i++) begin tick("R9"); if (!stpclk_n) cnt++; end
    chk("R9", "duty 0", cnt, 0);
    sw_en = 0; sw_duty = 3'd6; cnt = 0;
    for (int i = 0; i < 8; i++) begin tick("R10"); if (!stpclk_n) cnt++; end
    chk("R10", "sw disabled", cnt, 0);

    // Thermal override
    th_duty = 3'd5; sw_en = 1; sw_duty = 3'd1; therm_n = 0;
    tick("R10"); tick("R10");
    cnt = 0;
    for (int i = 0; i < 16; i++) begin tick("R10"); if (!stpclk_n) cnt++; end
    chk("R10", "thermal duty 5 over 16", cnt, 10);
    therm_n = 1; tick("R10"); tick("R10");
    cnt = 0;
    for (int i = 0; i < 16; i++) begin tick("R10"); if (!stpclk_n) cnt++; end
    chk("R10", "back to sw duty 1", cnt, 2);

    // Constrained random
    for (int i = 0; i < 6000; i++) begin
      lvl2_rd = ($urandom_range(0, 15) == 0);
      lvl3_rd = ($urandom_range(0, 19) == 0);
      halt    = ($urandom_range(0, 19) == 0);
      wake    = ($urandom_range(0, 9) == 0);
      hse     = $urandom_range(0, 1);
      relock  = 8'($urandom_range(0, 12));
      if ($urandom_range(0, 49) == 0) therm_n = ~therm_n;
      if ($urandom_range(0, 31) == 0) begin
        sw_en = $urandom_range(0, 1);
        sw_duty = 3'($urandom_range(0, 7));
        th_duty = 3'($urandom_range(0, 7));
      end
      tick(tag_of_state());
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule